// File: doc/BRIEF.md
# Memory Bus Sharing Arbiter

This block decides, clock by clock, whether a CPU or a DMA channel owns a single main-memory port. A two-bit policy input selects one of three sharing schemes. In **halt** mode the DMA asks the CPU for the bus and, once the CPU agrees, keeps it for a whole block transfer. In **slice** mode each CPU cycle is split into two memory slots. Slot C1 always goes to DMA and slot C2 always goes to the CPU, with no handshake. In **steal** mode the DMA takes single memory cycles whenever it can. It never cuts off a CPU access that is in progress, and it wins when both sides ask in the same cycle.

Ownership is held in a register, so a grant changes one clock after the inputs that cause it. The owner select output drives the memory multiplexer: 1 selects DMA and 0 selects the CPU. A policy change is applied only while the bus is idle. In halt mode a saturating counter records how many cycles the CPU spent locked out. All pins are plain control or status signals; no data passes through the block.

Top module: `membus_arbiter`

## Requirements
- R1: After reset the CPU owns the bus (owner_o=0), the policy is steal, phase_o=0, hold_req_o=0, dma_done_o=0 and stall_cnt_o=0.
- R2: Exactly one side owns memory in each cycle. dma_gnt_o equals owner_o, and cpu_gnt_o is cpu_req_i while owner_o=0 and 0 while owner_o=1.
- R3: Steal policy (mode_i=0, and also the unused code 3): while dma_req_i is low, the CPU keeps the bus on every cycle it requests.
- R4: Steal policy: if dma_req_i is high and cpu_busy_i is low, DMA owns the bus from the next cycle. This holds even when cpu_req_i is high in the same cycle, so DMA wins a tie.
- R5: Steal policy: while cpu_busy_i is high the CPU keeps the bus. A waiting DMA request is granted the cycle after cpu_busy_i falls.
- R6: Steal policy: DMA keeps the bus on consecutive cycles while dma_req_i stays high, and returns it the cycle after dma_req_i falls.
- R7: Slice policy (mode_i=2): phase_o toggles every clock. When phase_o=1 (slot C1) DMA owns the bus; when phase_o=0 (slot C2) the CPU owns it. No request or acknowledge is used, so a DMA request made in C2 is served in the next C1.
- R8: Halt policy (mode_i=1): a DMA request raises hold_req_o on the next cycle. DMA gains ownership only in the cycle after hold_ack_i is seen high.
- R9: Halt policy: DMA keeps the bus while dma_blk_i is high, so cpu_gnt_o stays low. The cycle after dma_blk_i falls, the CPU owns the bus again, hold_req_o falls and dma_done_o pulses for one cycle.
- R10: stall_cnt_o (16 bits) adds one for each cycle that DMA owned the bus under the halt policy. It saturates at 65535, and DMA cycles under the other policies do not count.
- R11: mode_i is applied only when the bus is idle: CPU owns it, dma_req_i and cpu_busy_i are low, and no halt handshake is open. Until then the old policy continues, so phase_o stays 0 when slice is requested while DMA holds the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Policy: 0 steal, 1 halt, 2 slice, 3 treated as steal |
| cpu_req_i | input | 1 | CPU wants memory |
| cpu_busy_i | input | 1 | A CPU memory access is in progress |
| cpu_gnt_o | output | 1 | CPU may use memory |
| dma_req_i | input | 1 | DMA wants memory |
| dma_blk_i | input | 1 | DMA block transfer still active (halt policy) |
| dma_gnt_o | output | 1 | DMA owns memory |
| hold_req_o | output | 1 | Bus request to the CPU (halt policy) |
| hold_ack_i | input | 1 | CPU has released the bus (halt policy) |
| dma_done_o | output | 1 | One-cycle pulse at the end of a halt-mode transfer |
| phase_o | output | 1 | Slot indicator: 1 is C1 (DMA), 0 is C2 (CPU) |
| owner_o | output | 1 | Memory owner select: 1 DMA, 0 CPU |
| stall_cnt_o | output | 16 | Saturating count of CPU-halted cycles |

## Verification
The properties assume a well-behaved environment. The CPU raises cpu_busy_i only while it owns the bus. hold_ack_i answers hold_req_o and is not raised on its own. dma_blk_i is high for the whole of a halt transfer. The stimulus drives every input on the falling clock edge and keeps to these rules. It drops dma_req_i together with dma_blk_i, withdraws hold_ack_i once hold_req_o has fallen, and changes mode_i only while ownership is in question or the bus is idle.

// File: rtl/membus_pkg.sv
package membus_pkg;
  typedef enum logic [1:0] {
    MODE_STEAL = 2'd0,
    MODE_HALT  = 2'd1,
    MODE_SLICE = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_XFER = 2'd2
  } halt_st_e;
endpackage

// File: rtl/membus_mode_reg.sv
module membus_mode_reg
  import membus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       idle_i,
  output mode_e      mode_o,
  output logic       chg_o
);
  mode_e mode_q, mode_req;

  always_comb begin
    unique case (mode_i)
      2'd1:    mode_req = MODE_HALT;
      2'd2:    mode_req = MODE_SLICE;
      default: mode_req = MODE_STEAL;
    endcase
  end

  assign chg_o = idle_i && (mode_req != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= MODE_STEAL;
    else if (chg_o) mode_q <= mode_req;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/membus_halt_ctl.sv
module membus_halt_ctl
  import membus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic dma_req_i,
  input  logic dma_blk_i,
  input  logic hold_ack_i,
  output logic own_d_o,
  output logic hold_req_o,
  output logic done_o,
  output logic idle_o
);
  halt_st_e st_q, st_d;
  logic     done_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_IDLE: if (en_i && dma_req_i) st_d = HS_REQ;
      HS_REQ:  if (hold_ack_i)        st_d = HS_XFER;
      HS_XFER: if (!dma_blk_i)        st_d = HS_IDLE;
      default:                        st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HS_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == HS_XFER) && !dma_blk_i;
    end
  end

  assign own_d_o    = (st_d == HS_XFER);
  assign hold_req_o = (st_q != HS_IDLE);
  assign done_o     = done_q;
  assign idle_o     = (st_q == HS_IDLE);
endmodule

// File: rtl/membus_slice_gen.sv
module membus_slice_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic clr_i,
  output logic phase_o,
  output logic phase_d_o
);
  logic phase_q;

  assign phase_d_o = (en_i && !clr_i) ? ~phase_q : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d_o;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/membus_stall_cnt.sv
module membus_stall_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (inc_i && cnt_q != MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/membus_arbiter.sv
module membus_arbiter
  import membus_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             cpu_req_i,
  input  logic             cpu_busy_i,
  output logic             cpu_gnt_o,
  input  logic             dma_req_i,
  input  logic             dma_blk_i,
  output logic             dma_gnt_o,
  output logic             hold_req_o,
  input  logic             hold_ack_i,
  output logic             dma_done_o,
  output logic             phase_o,
  output logic             owner_o,
  output logic [CNT_W-1:0] stall_cnt_o
);
  mode_e mode_q;
  logic  mode_chg, bus_idle, halt_idle, halt_own_d;
  logic  phase_d, own_d, owner_q;

  assign bus_idle = !owner_q && !dma_req_i && !cpu_busy_i && halt_idle;

  membus_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .idle_i (bus_idle),
    .mode_o (mode_q),
    .chg_o  (mode_chg)
  );

  membus_halt_ctl u_halt (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (mode_q == MODE_HALT),
    .dma_req_i  (dma_req_i),
    .dma_blk_i  (dma_blk_i),
    .hold_ack_i (hold_ack_i),
    .own_d_o    (halt_own_d),
    .hold_req_o (hold_req_o),
    .done_o     (dma_done_o),
    .idle_o     (halt_idle)
  );

  membus_slice_gen u_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (mode_q == MODE_SLICE),
    .clr_i     (mode_chg),
    .phase_o   (phase_o),
    .phase_d_o (phase_d)
  );

  always_comb begin
    unique case (mode_q)
      MODE_HALT:  own_d = halt_own_d;
      MODE_SLICE: own_d = phase_d;
      default:    own_d = owner_q ? dma_req_i : (dma_req_i && !cpu_busy_i);
    endcase
    if (mode_chg) own_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= 1'b0;
    else        owner_q <= own_d;
  end

  membus_stall_cnt #(.W(CNT_W)) u_stall (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (owner_q && (mode_q == MODE_HALT)),
    .cnt_o (stall_cnt_o)
  );

  assign owner_o   = owner_q;
  assign dma_gnt_o = owner_q;
  assign cpu_gnt_o = cpu_req_i && !owner_q;
endmodule

// File: rtl/membus_arbiter_chk.sv
module membus_arbiter_chk
  import membus_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_q,
  input logic             cpu_busy_i,
  input logic             cpu_gnt_o,
  input logic             dma_gnt_o,
  input logic             hold_req_o,
  input logic             hold_ack_i,
  input logic             dma_done_o,
  input logic             phase_o,
  input logic             owner_o,
  input logic [CNT_W-1:0] stall_cnt_o
);
  a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    dma_gnt_o |-> !cpu_gnt_o);

  a_r5_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STEAL && !owner_o && cpu_busy_i) |=> !owner_o);

  a_r7_slot_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SLICE && $past(mode_q) == MODE_SLICE) |-> (owner_o == phase_o));

  a_r7_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SLICE && $past(mode_q) == MODE_SLICE) |-> (phase_o != $past(phase_o)));

  a_r8_ack_first: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HALT && $rose(owner_o)) |-> $past(hold_req_o && hold_ack_i));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done_o |=> !dma_done_o);

  a_r9_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done_o |-> (!owner_o && $past(owner_o)));

  a_r10_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cnt_o != $past(stall_cnt_o)) |-> (stall_cnt_o == CNT_W'($past(stall_cnt_o) + 1'b1)));

  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (&stall_cnt_o) |=> (&stall_cnt_o));
endmodule

bind membus_arbiter membus_arbiter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_q      (mode_q),
  .cpu_busy_i  (cpu_busy_i),
  .cpu_gnt_o   (cpu_gnt_o),
  .dma_gnt_o   (dma_gnt_o),
  .hold_req_o  (hold_req_o),
  .hold_ack_i  (hold_ack_i),
  .dma_done_o  (dma_done_o),
  .phase_o     (phase_o),
  .owner_o     (owner_o),
  .stall_cnt_o (stall_cnt_o)
);

// File: tb/membus_arbiter_tb.sv
module membus_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        cpu_req_i = 1'b0, cpu_busy_i = 1'b0;
  logic        dma_req_i = 1'b0, dma_blk_i = 1'b0, hold_ack_i = 1'b0;
  logic        cpu_gnt_o, dma_gnt_o, hold_req_o, dma_done_o, phase_o, owner_o;
  logic [15:0] stall_cnt_o;

  int n_chk = 0, n_bad = 0;
  int exp_stall = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  membus_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .cpu_req_i(cpu_req_i), .cpu_busy_i(cpu_busy_i), .cpu_gnt_o(cpu_gnt_o),
    .dma_req_i(dma_req_i), .dma_blk_i(dma_blk_i), .dma_gnt_o(dma_gnt_o),
    .hold_req_o(hold_req_o), .hold_ack_i(hold_ack_i), .dma_done_o(dma_done_o),
    .phase_o(phase_o), .owner_o(owner_o), .stall_cnt_o(stall_cnt_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R1 owner", owner_o, 0);
    chk("R1 phase", phase_o, 0);
    chk("R1 hold_req", hold_req_o, 0);
    chk("R1 done", dma_done_o, 0);
    chk("R1 stall", stall_cnt_o, 0);
  endtask

  task automatic t_steal_cpu_only();
    cpu_req_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk("R3 cpu_gnt", cpu_gnt_o, 1);
      chk("R2 dma_gnt", dma_gnt_o, 0);
    end
    cpu_req_i = 1'b0;
    cyc();
    chk("R2 cpu_gnt follows req", cpu_gnt_o, 0);
  endtask

  task automatic t_steal_tie();
    cpu_req_i = 1'b1;
    dma_req_i = 1'b1;
    cyc();
    chk("R4 dma wins tie", dma_gnt_o, 1);
    chk("R2 cpu_gnt low", cpu_gnt_o, 0);
    cyc(3);
    chk("R6 dma keeps bus", owner_o, 1);
    dma_req_i = 1'b0;
    cyc();
    chk("R6 released", owner_o, 0);
    chk("R3 cpu regains", cpu_gnt_o, 1);
    cpu_req_i = 1'b0;
  endtask

  task automatic t_steal_busy();
    cpu_req_i  = 1'b1;
    cpu_busy_i = 1'b1;
    cyc();
    dma_req_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R5 wait for cpu access", dma_gnt_o, 0);
    end
    cpu_busy_i = 1'b0;
    cyc();
    chk("R5 granted after access", dma_gnt_o, 1);
    dma_req_i = 1'b0;
    cpu_req_i = 1'b0;
    cyc();
    chk("R6 released", owner_o, 0);
    chk("R10 steal not counted", stall_cnt_o, 0);
  endtask

  task automatic t_mode_defer_slice();
    dma_req_i = 1'b1;
    cyc();
    mode_i = 2'd2;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R11 slice deferred", phase_o, 0);
    end
    dma_req_i = 1'b0;
    cyc(2);
    chk("R11 still C2 while switching", phase_o, 0);
    cpu_req_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      cyc();
      chk("R7 phase", phase_o, (i % 2 == 0) ? 1 : 0);
      chk("R7 slot owner", dma_gnt_o, (i % 2 == 0) ? 1 : 0);
      chk("R7 cpu in C2", cpu_gnt_o, (i % 2 == 0) ? 0 : 1);
    end
    cpu_req_i = 1'b0;
  endtask

  task automatic t_to_halt();
    mode_i = 2'd1;
    cyc(4);
    chk("R11 phase cleared", phase_o, 0);
    chk("R11 cpu owns after switch", owner_o, 0);
  endtask

  task automatic t_halt_xfer(int len, bit check_each);
    int seen = 0;
    cpu_req_i = 1'b1;
    dma_req_i = 1'b1;
    dma_blk_i = 1'b1;
    cyc();
    chk("R8 hold_req raised", hold_req_o, 1);
    cyc(2);
    chk("R8 no grant before ack", dma_gnt_o, 0);
    hold_ack_i = 1'b1;
    cyc();
    chk("R8 grant after ack", dma_gnt_o, 1);
    if (dma_gnt_o) seen++;
    for (int i = 0; i < len; i++) begin
      cyc();
      if (dma_gnt_o) seen++;
      if (check_each) chk("R9 cpu_gnt low", cpu_gnt_o, 0);
    end
    dma_blk_i = 1'b0;
    dma_req_i = 1'b0;
    cyc();
    chk("R9 bus returned", owner_o, 0);
    chk("R9 done pulse", dma_done_o, 1);
    chk("R9 hold_req dropped", hold_req_o, 0);
    hold_ack_i = 1'b0;
    cyc();
    chk("R9 done single cycle", dma_done_o, 0);
    chk("R9 cpu granted", cpu_gnt_o, 1);
    exp_stall = exp_stall + seen;
    if (exp_stall > 65535) exp_stall = 65535;
    chk("R10 stall count", stall_cnt_o, exp_stall);
    cpu_req_i = 1'b0;
  endtask

  initial begin
    cyc(2);
    rst_n = 1'b1;
    t_reset();
    t_steal_cpu_only();
    t_steal_tie();
    t_steal_busy();
    t_mode_defer_slice();
    t_to_halt();
    t_halt_xfer(5, 1'b1);
    t_halt_xfer(70000, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule